// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus qualifier of a parallel NOR flash model. It watches qualified write cycles (address plus data byte), recognises the multi-write unlock sequences that select an operation, and holds the device mode. When a program or erase sequence completes, it emits a one-cycle start pulse with the target, and it follows the embedded-operation model through its `busy_i` and `err_i` flags. It also tells the read path whether a read returns array contents, status, or identification data.

Unlock cycles are `AAh` at command address `555h`, then `55h` at `2AAh`. Only the low 11 address bits are compared. The third write, at `555h`, picks the operation. A fast-program mode lets repeated programs skip the unlock pair. An erase can be suspended. While it is suspended, programs and identification reads are allowed, and reads from the sector being erased return status.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode_o` is 0 (read array), `rd_sel_o` is 0 (array), and both start pulses are low. Mode codes: 0 read array, 1 identify, 2 program, 3 erase, 4 erase suspended, 5 fast program. Read select codes: 0 array, 1 status, 2 identify.
- R2: The writes `AAh@555h`, `55h@2AAh`, `A0h@555h`, then `D@A` raise `prog_start_o` for one cycle in the cycle after the last write, with `tgt_addr_o`=A and `tgt_data_o`=D, and move the mode to 2 (read select 1).
- R3: A write with the wrong data or the wrong command address at any unlock or selection cycle abandons the sequence, and the mode stays in its base mode. A later write that only completes the abandoned sequence starts nothing.
- R4: `F0h` written at any address between sequence cycles abandons the sequence. The remaining cycles then start nothing.
- R5: While mode is 2 or 3 and `err_i` is low, `F0h` and other writes are ignored. Once `busy_i` has been high and then falls, the mode returns to its origin: 0, or 4 for a program issued while suspended, or 5 for a fast program.
- R6: `90h@555h` as the third write enters mode 1 with read select 2. Only `F0h` leaves it, returning to 0, or to 4 if identify was entered from the suspended state.
- R7: While mode is 2 or 3 and `err_i` is high, `F0h` returns the mode to 0 and clears any erase marking.
- R8: `20h@555h` as the third write enters mode 5. There `A0h` at any address followed by `D@A` starts a program, and the mode returns to 5 when it completes. `90h` then `00h` exits to 0. `90h` followed by any other byte stays in 5.
- R9: After the unlock pair, `80h@555h`, and the unlock pair again, `30h@A` starts a sector erase of the sector of A, and `10h@555h` starts a chip erase. Both raise `erase_start_o` for one cycle with mode 3 and `tgt_addr_o`=A, and `chip_erase_o` is 1 only for chip erase. Sector index is the top log2(NUM_SECT) address bits.
- R10: In mode 3, `B0h` enters mode 4. In mode 4, `30h` at any address resumes mode 3. Erase completion clears the marked sectors.
- R11: In mode 4, `rd_sel_o` is 1 for read addresses in a marked sector and 0 elsewhere. This still holds after a program issued and completed during suspension.
- R12: In mode 4, `20h` and `80h` as third writes are refused, and the mode stays 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Qualified write strobe, one cycle per bus write |
| addr_i | input | ADDR_W | Write address |
| data_i | input | 8 | Write data byte |
| rd_addr_i | input | ADDR_W | Current read address |
| busy_i | input | 1 | Embedded operation running |
| err_i | input | 1 | Embedded operation failed (status bit 5) |
| mode_o | output | 3 | Current device mode code |
| rd_sel_o | output | 2 | Read data source select |
| prog_start_o | output | 1 | One-cycle program start pulse |
| erase_start_o | output | 1 | One-cycle erase start pulse |
| chip_erase_o | output | 1 | Last erase start was a chip erase |
| tgt_addr_o | output | ADDR_W | Target address of last started operation |
| tgt_data_o | output | 8 | Program data of last started program |

## Verification
A wrong sequence step shows up at the ports on the write that should have completed a command. The pulse is missing or spurious one cycle after that write, so sweeps pair every wrong byte or address with the remaining cycles of the sequence. A lost return mode appears one cycle after `busy_i` falls, as the wrong `mode_o`. A stale or misplaced erase mark shows as a wrong `rd_sel_o` as soon as the read address enters that sector in suspended mode, so the read address is swept across every sector.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMD_W = 11;
  localparam logic [CMD_W-1:0] KEY_A = 11'h555;
  localparam logic [CMD_W-1:0] KEY_B = 11'h2AA;

  localparam logic [7:0] C_UNL1  = 8'hAA;
  localparam logic [7:0] C_UNL2  = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_IDENT = 8'h90;
  localparam logic [7:0] C_FAST  = 8'h20;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_RESET = 8'hF0;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_ZERO  = 8'h00;

  typedef enum logic [2:0] {
    MD_READ  = 3'd0,
    MD_IDENT = 3'd1,
    MD_PROG  = 3'd2,
    MD_ERASE = 3'd3,
    MD_SUSP  = 3'd4,
    MD_FAST  = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_ER1, ST_ER2, ST_ER3, ST_PDATA, ST_FXIT
  } step_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_STATUS = 2'd1,
    RS_IDENT  = 2'd2
  } rdsel_e;

  typedef struct packed {
    logic wr;
    logic key;
    logic unl1;
    logic unl2;
    logic rst;
    logic prog;
    logic ident;
    logic fast;
    logic ers;
    logic c30;
    logic c10;
    logic susp;
    logic zero;
  } cmd_t;

endpackage

// File: rtl/fcd_cmd_match.sv
module fcd_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output cmd_t              cmd_o
);

  logic [CMD_W-1:0] low;
  assign low = addr_i[CMD_W-1:0];

  always_comb begin
    cmd_o.wr    = wr_i;
    cmd_o.key   = wr_i && (low == KEY_A);
    cmd_o.unl1  = wr_i && (low == KEY_A) && (data_i == C_UNL1);
    cmd_o.unl2  = wr_i && (low == KEY_B) && (data_i == C_UNL2);
    cmd_o.rst   = wr_i && (data_i == C_RESET);
    cmd_o.prog  = wr_i && (data_i == C_PROG);
    cmd_o.ident = wr_i && (data_i == C_IDENT);
    cmd_o.fast  = wr_i && (data_i == C_FAST);
    cmd_o.ers   = wr_i && (data_i == C_ERASE);
    cmd_o.c30   = wr_i && (data_i == C_SECT);
    cmd_o.c10   = wr_i && (data_i == C_CHIP);
    cmd_o.susp  = wr_i && (data_i == C_SUSP);
    cmd_o.zero  = wr_i && (data_i == C_ZERO);
  end

endmodule

// File: rtl/fcd_op_track.sv
module fcd_op_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_active_i,
  input  logic op_enter_i,
  input  logic busy_i,
  input  logic err_i,
  output logic done_o
);

  logic seen_q;

  // completion needs a busy high phase after entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      seen_q <= 1'b0;
    else if (op_enter_i)              seen_q <= 1'b0;
    else if (op_active_i && busy_i)   seen_q <= 1'b1;
    else if (!op_active_i)            seen_q <= 1'b0;
  end

  assign done_o = op_active_i && seen_q && !busy_i && !err_i;

  // R5
  no_early_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_enter_i && !op_active_i) |=> !done_o);

endmodule

// File: rtl/fcd_read_sel.sv
module fcd_read_sel
  import flash_cmd_pkg::*;
#(
  parameter int NUM_SECT = 16,
  parameter int SECT_W   = $clog2(NUM_SECT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              mark_one_i,
  input  logic              mark_all_i,
  input  logic              clear_i,
  input  logic [SECT_W-1:0] mark_idx_i,
  input  logic [SECT_W-1:0] rd_idx_i,
  output logic [1:0]        rd_sel_o
);

  logic [NUM_SECT-1:0] mask_q;

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         mask_q[g] <= 1'b0;
      else if (clear_i)                                    mask_q[g] <= 1'b0;
      else if (mark_all_i)                                 mask_q[g] <= 1'b1;
      else if (mark_one_i && (mark_idx_i == SECT_W'(g)))   mask_q[g] <= 1'b1;
    end
  end

  always_comb begin
    unique case (mode_i)
      MD_IDENT:          rd_sel_o = RS_IDENT;
      MD_PROG, MD_ERASE: rd_sel_o = RS_STATUS;
      MD_SUSP:           rd_sel_o = mask_q[rd_idx_i] ? RS_STATUS : RS_ARRAY;
      default:           rd_sel_o = RS_ARRAY;
    endcase
  end

  // R9
  chip_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_all_i && !clear_i) |=> (&mask_q));

  // R10
  clear_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (mask_q == '0));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_SECT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              busy_i,
  input  logic              err_i,
  output logic [2:0]        mode_o,
  output logic [1:0]        rd_sel_o,
  output logic              prog_start_o,
  output logic              erase_start_o,
  output logic              chip_erase_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [7:0]        tgt_data_o
);

  localparam int SECT_W = $clog2(NUM_SECT);

  cmd_t  cmd;
  mode_e mode_q, mode_d, ret_q, ret_d;
  step_e step_q, step_d;
  logic  ps_q, ps_d, es_q, es_d, chip_q, chip_d;
  logic [ADDR_W-1:0] taddr_q, taddr_d;
  logic [7:0]        tdata_q, tdata_d;
  logic  op_enter, op_done, op_active;
  logic  mark_one, mark_all, mark_clr;
  logic  suspended;

  fcd_cmd_match #(.ADDR_W(ADDR_W)) u_match (
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .data_i (data_i),
    .cmd_o  (cmd)
  );

  assign op_active = (mode_q == MD_PROG) || (mode_q == MD_ERASE);
  assign suspended = (mode_q == MD_SUSP);

  fcd_op_track u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_active_i (op_active),
    .op_enter_i  (op_enter),
    .busy_i      (busy_i),
    .err_i       (err_i),
    .done_o      (op_done)
  );

  always_comb begin
    mode_d   = mode_q;
    step_d   = step_q;
    ret_d    = ret_q;
    ps_d     = 1'b0;
    es_d     = 1'b0;
    chip_d   = chip_q;
    taddr_d  = taddr_q;
    tdata_d  = tdata_q;
    op_enter = 1'b0;
    mark_one = 1'b0;
    mark_all = 1'b0;
    mark_clr = 1'b0;
    unique case (mode_q)
      MD_PROG, MD_ERASE: begin
        step_d = ST_IDLE;
        if (op_done) begin
          mode_d = (mode_q == MD_PROG) ? ret_q : MD_READ;
          mark_clr = (mode_q == MD_ERASE);
        end else if (cmd.rst && err_i) begin
          mode_d   = MD_READ;
          mark_clr = 1'b1;
        end else if ((mode_q == MD_ERASE) && cmd.susp) begin
          mode_d = MD_SUSP;
        end
      end
      MD_IDENT: begin
        step_d = ST_IDLE;
        if (cmd.rst) mode_d = ret_q;
      end
      MD_FAST: begin
        unique case (step_q)
          ST_PDATA: if (cmd.wr) begin
            ps_d     = 1'b1;
            taddr_d  = addr_i;
            tdata_d  = data_i;
            ret_d    = MD_FAST;
            mode_d   = MD_PROG;
            op_enter = 1'b1;
            step_d   = ST_IDLE;
          end
          ST_FXIT: if (cmd.wr) begin
            step_d = ST_IDLE;
            if (cmd.zero) mode_d = MD_READ;
          end
          default: begin
            step_d = ST_IDLE;
            if (cmd.prog)       step_d = ST_PDATA;
            else if (cmd.ident) step_d = ST_FXIT;
          end
        endcase
      end
      MD_READ, MD_SUSP: begin
        unique case (step_q)
          ST_IDLE: if (cmd.unl1) begin
            step_d = ST_UNL1;
          end else if (suspended && cmd.c30) begin
            mode_d   = MD_ERASE;
            op_enter = 1'b1;
          end
          ST_UNL1: if (cmd.wr) step_d = cmd.unl2 ? ST_UNL2 : ST_IDLE;
          ST_UNL2: if (cmd.wr) begin
            step_d = ST_IDLE;
            if (cmd.key) begin
              if (cmd.prog) begin
                step_d = ST_PDATA;
              end else if (cmd.ident) begin
                ret_d  = mode_q;
                mode_d = MD_IDENT;
              end else if (cmd.fast && !suspended) begin
                mode_d = MD_FAST;
              end else if (cmd.ers && !suspended) begin
                step_d = ST_ER1;
              end
            end
          end
          ST_ER1: if (cmd.wr) step_d = cmd.unl1 ? ST_ER2 : ST_IDLE;
          ST_ER2: if (cmd.wr) step_d = cmd.unl2 ? ST_ER3 : ST_IDLE;
          ST_ER3: if (cmd.wr) begin
            step_d = ST_IDLE;
            if (cmd.c30) begin
              es_d     = 1'b1;
              chip_d   = 1'b0;
              taddr_d  = addr_i;
              mark_one = 1'b1;
              mode_d   = MD_ERASE;
              op_enter = 1'b1;
            end else if (cmd.c10 && cmd.key) begin
              es_d     = 1'b1;
              chip_d   = 1'b1;
              taddr_d  = addr_i;
              mark_all = 1'b1;
              mode_d   = MD_ERASE;
              op_enter = 1'b1;
            end
          end
          ST_PDATA: if (cmd.wr) begin
            ps_d     = 1'b1;
            taddr_d  = addr_i;
            tdata_d  = data_i;
            ret_d    = mode_q;
            mode_d   = MD_PROG;
            op_enter = 1'b1;
            step_d   = ST_IDLE;
          end
          default: step_d = ST_IDLE;
        endcase
      end
      default: begin
        mode_d = MD_READ;
        step_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MD_READ;
      step_q  <= ST_IDLE;
      ret_q   <= MD_READ;
      ps_q    <= 1'b0;
      es_q    <= 1'b0;
      chip_q  <= 1'b0;
      taddr_q <= '0;
      tdata_q <= '0;
    end else begin
      mode_q  <= mode_d;
      step_q  <= step_d;
      ret_q   <= ret_d;
      ps_q    <= ps_d;
      es_q    <= es_d;
      chip_q  <= chip_d;
      taddr_q <= taddr_d;
      tdata_q <= tdata_d;
    end
  end

  fcd_read_sel #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_rsel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .mark_one_i (mark_one),
    .mark_all_i (mark_all),
    .clear_i    (mark_clr),
    .mark_idx_i (addr_i[ADDR_W-1 -: SECT_W]),
    .rd_idx_i   (rd_addr_i[ADDR_W-1 -: SECT_W]),
    .rd_sel_o   (rd_sel_o)
  );

  assign mode_o        = mode_q;
  assign prog_start_o  = ps_q;
  assign erase_start_o = es_q;
  assign chip_erase_o  = chip_q;
  assign tgt_addr_o    = taddr_q;
  assign tgt_data_o    = tdata_q;

  // R2
  prog_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> (mode_o == MD_PROG));

  // R9
  start_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, erase_start_o}));

  // R5
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_active && busy_i && !err_i && cmd.rst) |=> (mode_q == $past(mode_q)));

  // R6
  ident_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MD_IDENT) && cmd.wr && !cmd.rst) |=> (mode_q == MD_IDENT));

  // R8
  fast_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MD_FAST) && (step_q == ST_IDLE) && cmd.wr && !cmd.prog && !cmd.ident)
      |=> (mode_q == MD_FAST));

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  localparam int AW = 12;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          busy = 1'b0;
  logic          err = 1'b0;
  logic [2:0]    mode;
  logic [1:0]    rd_sel;
  logic          ps, es, chip;
  logic [AW-1:0] taddr;
  logic [7:0]    tdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic saw_ps, saw_es;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .NUM_SECT(NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_en), .addr_i(addr), .data_i(data),
    .rd_addr_i(rd_addr), .busy_i(busy), .err_i(err), .mode_o(mode),
    .rd_sel_o(rd_sel), .prog_start_o(ps), .erase_start_o(es),
    .chip_erase_o(chip), .tgt_addr_o(taddr), .tgt_data_o(tdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    saw_ps = ps;
    saw_es = es;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic busy_run(input int n);
    @(negedge clk); busy = 1'b1;
    repeat (n) @(negedge clk);
    busy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic erase_sect(input logic [AW-1:0] a);
    unlock(); wr(12'h555, 8'h80); unlock(); wr(a, 8'h30);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 mode", mode, 0);
    check("R1 rd_sel", rd_sel, 0);
    check("R1 pulses", {ps, es}, 0);

    // R2 standard program
    unlock(); wr(12'h555, 8'hA0); wr(12'h123, 8'h5A);
    check("R2 pulse", saw_ps, 1);
    check("R2 addr", taddr, 12'h123);
    check("R2 data", tdata, 8'h5A);
    check("R2 mode", mode, 2);
    check("R2 rd_sel", rd_sel, 1);
    @(negedge clk);
    check("R2 one cycle", ps, 0);
    busy_run(3);
    check("R5 return read", mode, 0);

    // R3 wrong first data byte
    for (int d = 0; d < 256; d++) begin
      if (d == 8'hAA) continue;
      wr(12'h555, 8'(d)); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h100, 8'h11);
      check("R3 first byte", {saw_ps, mode}, 0);
    end
    // R3 wrong second data byte
    for (int d = 0; d < 256; d++) begin
      if (d == 8'h55) continue;
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'(d)); wr(12'h555, 8'hA0); wr(12'h100, 8'h11);
      check("R3 second byte", {saw_ps, mode}, 0);
    end
    // R3 unknown third byte
    for (int d = 0; d < 256; d++) begin
      if (d == 8'hA0 || d == 8'h90 || d == 8'h20 || d == 8'h80) continue;
      unlock(); wr(12'h555, 8'(d)); wr(12'h100, 8'h11);
      check("R3 third byte", {saw_ps, mode}, 0);
    end
    // R3 address of second unlock cycle swept
    for (int a = 0; a < 4096; a += 7) begin
      bit good;
      good = ((a & 12'h7FF) == 12'h2AA);
      wr(12'h555, 8'hAA); wr(12'(a), 8'h55); wr(12'h555, 8'hA0); wr(12'h100, 8'h11);
      check("R3 unlock address", saw_ps, int'(good));
      if (good) busy_run(1);
    end

    // R4 reset between erase cycles
    for (int k = 1; k <= 5; k++) begin
      logic [AW-1:0] sa [6];
      logic [7:0]    sd [6];
      sa = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'h600};
      sd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
      for (int i = 0; i < k; i++) wr(sa[i], sd[i]);
      wr(12'h000, 8'hF0);
      check("R4 reset mode", mode, 0);
      for (int i = k; i < 6; i++) begin
        wr(sa[i], sd[i]);
        check("R4 no erase", saw_es, 0);
      end
    end

    // R9 sector erase
    erase_sect(12'h600);
    check("R9 pulse", saw_es, 1);
    check("R9 chip flag", chip, 0);
    check("R9 addr", taddr, 12'h600);
    check("R9 mode", mode, 3);
    busy_run(2);
    check("R9 done", mode, 0);
    // R9 chip erase
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h10);
    check("R9 chip pulse", saw_es, 1);
    check("R9 chip flag set", chip, 1);
    busy_run(2);
    check("R9 chip done", mode, 0);

    // R5 reset ignored while busy
    unlock(); wr(12'h555, 8'hA0); wr(12'h040, 8'h33);
    @(negedge clk); busy = 1'b1;
    wr(12'h000, 8'hF0);
    check("R5 F0 ignored", mode, 2);
    wr(12'h000, 8'hB0);
    check("R5 B0 ignored", mode, 2);
    busy = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 done", mode, 0);

    // R7 error then reset
    erase_sect(12'h200);
    @(negedge clk); busy = 1'b1;
    @(negedge clk); err = 1'b1;
    @(negedge clk);
    check("R7 stuck in erase", mode, 3);
    wr(12'h000, 8'hF0);
    check("R7 reset mode", mode, 0);
    check("R7 rd_sel", rd_sel, 0);
    busy = 1'b0; err = 1'b0;
    @(negedge clk);
    check("R7 stays read", mode, 0);

    // R6 identify
    unlock(); wr(12'h555, 8'h90);
    check("R6 mode", mode, 1);
    check("R6 rd_sel", rd_sel, 2);
    for (int d = 0; d < 256; d++) begin
      if (d == 8'hF0) continue;
      wr(12'h555, 8'(d));
      check("R6 hold", mode, 1);
    end
    wr(12'h3FF, 8'hF0);
    check("R6 exit", mode, 0);

    // R8 fast program
    unlock(); wr(12'h555, 8'h20);
    check("R8 enter", mode, 5);
    for (int i = 0; i < 4; i++) begin
      wr(12'h007, 8'hA0); wr(12'(12'h200 + i), 8'(i * 3));
      check("R8 pulse", saw_ps, 1);
      check("R8 addr", taddr, 12'h200 + i);
      check("R8 data", tdata, i * 3);
      busy_run(2);
      check("R8 back to fast", mode, 5);
    end
    wr(12'h000, 8'h55);
    check("R8 stray kept", mode, 5);
    wr(12'h000, 8'h90); wr(12'h000, 8'h01);
    check("R8 bad exit", mode, 5);
    wr(12'h000, 8'h90); wr(12'h000, 8'h00);
    check("R8 exit", mode, 0);

    // R10 / R11 suspend with sector 3 marked
    erase_sect(12'h600);
    @(negedge clk); busy = 1'b1;
    wr(12'h000, 8'hB0);
    check("R10 suspend", mode, 4);
    busy = 1'b0;
    for (int a = 0; a < 4096; a += 16) begin
      @(negedge clk); rd_addr = 12'(a);
      #1 check("R11 read select", rd_sel, ((a >> 9) == 3) ? 1 : 0);
    end
    // R12 refused third writes
    unlock(); wr(12'h555, 8'h20);
    check("R12 fast refused", mode, 4);
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h800, 8'h30);
    check("R12 erase refused", {saw_es, mode}, 4);
    // R11 program while suspended
    unlock(); wr(12'h555, 8'hA0); wr(12'h010, 8'h77);
    check("R11 prog pulse", saw_ps, 1);
    busy_run(2);
    check("R11 back to suspend", mode, 4);
    @(negedge clk); rd_addr = 12'h600;
    #1 check("R11 marked", rd_sel, 1);
    @(negedge clk); rd_addr = 12'h010;
    #1 check("R11 unmarked", rd_sel, 0);
    // R6 identify from suspend
    unlock(); wr(12'h555, 8'h90);
    check("R6 ident in suspend", mode, 1);
    wr(12'h000, 8'hF0);
    check("R6 back to suspend", mode, 4);
    // R10 resume and finish
    wr(12'h123, 8'h30);
    check("R10 resume", mode, 3);
    busy_run(2);
    check("R10 done", mode, 0);
    @(negedge clk); rd_addr = 12'h600;
    #1 check("R10 mask cleared", rd_sel, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule